// File: doc/BRIEF.md
# Smart-Card Character Receiver with Parity NACK

This block receives asynchronous smart-card characters in the T=0 style from one shared, open-drain I/O line. A baud generator outside the block supplies a clock enable that pulses `BIT_TICKS` times per bit. The block looks for a falling edge and confirms the start bit at its midpoint. It then samples eight data bits, least significant first, and a parity bit, each in the middle of its bit period.

When a character fails its parity check, the receiver can pull the line low for one bit time during the guard period. This error signal asks the card or reader at the other end to send the character again. The local policy controls what happens instead. With inhibit enabled, the NACK is suppressed but the character is kept and a sticky flag records the event. With the successive-NACK cap enabled, after a programmed number of NACKs for the same character, that character is accepted as though it were good and a sticky flag is set.

The received byte sits in a holding register together with a ready flag. A saturating count of parity errors clears when it is read. The line driver, baud generation and the transmit direction are handled elsewhere.

Top module: `t0_char_rx`

## Requirements
- R1: Characters are sent least significant bit first. After a frame with good parity, `rx_byte[0]` holds D0 and `rx_byte[7]` holds D7, and `rx_ready` is 1.
- R2: Parity is even over the nine bits D0 to D7 plus the parity bit. A frame whose nine bits hold an odd number of ones is a parity error.
- R3: On a parity error with inhibit off and the cap not reached, `io_pull_low` is 1 for exactly `BIT_TICKS` ticks. It starts half a bit after the parity sample. A good frame never asserts it.
- R4: `err_count` increases by one for every parity error, whatever the NACK policy does. It saturates at all ones (255 by default).
- R5: A one-cycle pulse on `err_count_rd` sets `err_count` to 0 on the next cycle.
- R6: With `cfg_nack_inhibit` = 1, a bad-parity character gives no pull-low. Its data is stored in `rx_byte`, `rx_ready` does not rise, and `inack_flag` is set.
- R7: `inack_flag` stays set through later frames and falls only after an `inack_clr` pulse.
- R8: With `cfg_nack_limit_en` = 1 and `cfg_nack_max` = M, the first M successive bad characters are NACKed. The next bad character is accepted: it is stored, `rx_ready` rises, there is no pull-low, and `iter_flag` is set.
- R9: `iter_flag` stays set until an `iter_clr` pulse clears it.
- R10: A character with good parity resets the count of successive NACKs to zero.
- R11: A pulse on `rx_taken` clears `rx_ready`.
- R12: A low pulse on an idle line that is high again at the start-bit midpoint is ignored. No character, no error and no pull-low result from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_tick | input | 1 | Clock enable, `BIT_TICKS` pulses per bit |
| io_line | input | 1 | Sampled level of the shared I/O line |
| io_pull_low | output | 1 | Request to drive the line low (error signal) |
| cfg_nack_inhibit | input | 1 | Suppress NACKs, keep bad characters |
| cfg_nack_limit_en | input | 1 | Enable the successive-NACK cap |
| cfg_nack_max | input | MAXW | Maximum NACKs per character when capped |
| rx_byte | output | 8 | Holding register for the received character |
| rx_ready | output | 1 | A good or forced-accepted character is waiting |
| rx_taken | input | 1 | Strobe: clear `rx_ready` |
| err_count | output | ERRW | Saturating parity-error count |
| err_count_rd | input | 1 | Strobe: count read, clear it |
| inack_flag | output | 1 | Sticky: an inhibited error occurred |
| inack_clr | input | 1 | Strobe: clear `inack_flag` |
| iter_flag | output | 1 | Sticky: the NACK cap was reached |
| iter_clr | input | 1 | Strobe: clear `iter_flag` |

## Verification
Every one of the 256 byte values is sent with correct parity. This exposes any bit-order, sampling-offset or parity-polarity fault, because each data bit is seen both as 0 and as 1 next to every other bit. A set of bytes is then resent with flipped parity under each of three policies: plain NACK, inhibit, and the cap. In each case the bench compares pull-low length, stored data and the ready flag, which separates the three outcomes. Runs of bad characters with and without a good one in between separate a cap that resets on good parity from one that does not. A long stream of errors and a glitch on the start bit test counter saturation and false-start rejection.

// File: rtl/t0rx_pkg.sv
package t0rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_GAP,
    ST_SIGNAL,
    ST_GUARD
  } rx_state_e;

  typedef enum logic [1:0] {
    OUT_GOOD,
    OUT_NACK,
    OUT_INHIBIT,
    OUT_FORCED
  } outcome_e;

endpackage

// File: rtl/t0rx_frame.sv
module t0rx_frame
  import t0rx_pkg::*;
#(
  parameter int BIT_TICKS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       line_i,
  input  logic       nack_i,
  output logic       done_o,
  output logic [7:0] byte_o,
  output logic       par_ok_o,
  output logic       drive_o
);

  localparam int CW = (BIT_TICKS > 1) ? $clog2(BIT_TICKS) : 1;
  localparam int HALF = BIT_TICKS / 2;
  localparam logic [CW-1:0] LAST  = CW'(BIT_TICKS - 1);
  localparam logic [CW-1:0] HLAST = CW'(HALF - 1);

  rx_state_e     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [3:0]    idx_q, idx_d;
  logic [7:0]    sr_q, sr_d;
  logic          nack_q, nack_d;
  logic          done;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    idx_d  = idx_q;
    sr_d   = sr_q;
    nack_d = nack_q;
    done   = 1'b0;
    if (tick_i) begin
      case (st_q)
        ST_IDLE: begin
          if (!line_i) begin
            st_d  = ST_START;
            cnt_d = '0;
          end
        end
        ST_START: begin
          if (cnt_q == HLAST) begin
            cnt_d = '0;
            idx_d = '0;
            st_d  = line_i ? ST_IDLE : ST_DATA;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_DATA: begin
          if (cnt_q == LAST) begin
            cnt_d = '0;
            if (idx_q == 4'd8) begin
              done = 1'b1;
              st_d = ST_GAP;
            end else begin
              sr_d  = {line_i, sr_q[7:1]};
              idx_d = idx_q + 1'b1;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_GAP: begin
          if (cnt_q == HLAST) begin
            cnt_d = '0;
            st_d  = ST_SIGNAL;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_SIGNAL: begin
          if (cnt_q == LAST) begin
            cnt_d = '0;
            st_d  = ST_GUARD;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_GUARD: begin
          if (cnt_q == LAST) begin
            cnt_d = '0;
            st_d  = ST_IDLE;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
    if (done) nack_d = nack_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sr_q   <= '0;
      nack_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      sr_q   <= sr_d;
      nack_q <= nack_d;
    end
  end

  assign done_o   = done;
  assign byte_o   = sr_q;
  assign par_ok_o = ~(^sr_q ^ line_i);
  assign drive_o  = (st_q == ST_SIGNAL) && nack_q;

  // R3
  nack_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_o) |-> $past(st_q) == ST_GAP);

  // R3
  nack_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drive_o) |-> st_q == ST_GUARD);

endmodule

// File: rtl/t0rx_policy.sv
module t0rx_policy
  import t0rx_pkg::*;
#(
  parameter int MAXW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            done_i,
  input  logic            par_ok_i,
  input  logic [7:0]      byte_i,
  input  logic            inhibit_i,
  input  logic            limit_en_i,
  input  logic [MAXW-1:0] max_i,
  input  logic            taken_i,
  input  logic            clr_inack_i,
  input  logic            clr_iter_i,
  output logic            nack_o,
  output logic [7:0]      data_o,
  output logic            ready_o,
  output logic            inack_o,
  output logic            iter_o
);

  localparam logic [MAXW-1:0] NCNT_TOP = {MAXW{1'b1}};

  outcome_e        outcome;
  logic [MAXW-1:0] ncnt_q, ncnt_d;
  logic [7:0]      hold_q, hold_d;
  logic            ready_q, ready_d;
  logic            inack_q, inack_d;
  logic            iter_q, iter_d;

  always_comb begin
    if (par_ok_i)                            outcome = OUT_GOOD;
    else if (inhibit_i)                      outcome = OUT_INHIBIT;
    else if (limit_en_i && (ncnt_q >= max_i)) outcome = OUT_FORCED;
    else                                     outcome = OUT_NACK;
  end

  always_comb begin
    ncnt_d  = ncnt_q;
    hold_d  = hold_q;
    ready_d = ready_q & ~taken_i;
    inack_d = inack_q & ~clr_inack_i;
    iter_d  = iter_q & ~clr_iter_i;
    if (done_i) begin
      case (outcome)
        OUT_GOOD: begin
          hold_d  = byte_i;
          ready_d = 1'b1;
          ncnt_d  = '0;
        end
        OUT_INHIBIT: begin
          hold_d  = byte_i;
          inack_d = 1'b1;
        end
        OUT_FORCED: begin
          hold_d  = byte_i;
          ready_d = 1'b1;
          iter_d  = 1'b1;
          ncnt_d  = '0;
        end
        default: begin
          if (ncnt_q != NCNT_TOP) ncnt_d = ncnt_q + 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ncnt_q  <= '0;
      hold_q  <= '0;
      ready_q <= 1'b0;
      inack_q <= 1'b0;
      iter_q  <= 1'b0;
    end else begin
      ncnt_q  <= ncnt_d;
      hold_q  <= hold_d;
      ready_q <= ready_d;
      inack_q <= inack_d;
      iter_q  <= iter_d;
    end
  end

  assign nack_o  = done_i && (outcome == OUT_NACK);
  assign data_o  = hold_q;
  assign ready_o = ready_q;
  assign inack_o = inack_q;
  assign iter_o  = iter_q;

  // R7
  inack_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inack_q && !clr_inack_i) |=> inack_q);

  // R9
  iter_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iter_q && !clr_iter_i) |=> iter_q);

  // R6
  inhibit_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && !par_ok_i && inhibit_i) |=> data_o == $past(byte_i));

  // R10
  good_resets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && par_ok_i) |=> ncnt_q == '0);

endmodule

// File: rtl/t0rx_errcnt.sv
module t0rx_errcnt #(
  parameter int ERRW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            inc_i,
  input  logic            clr_i,
  output logic [ERRW-1:0] cnt_o
);

  localparam logic [ERRW-1:0] TOP = {ERRW{1'b1}};

  logic [ERRW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)                        cnt_d = inc_i ? ERRW'(1) : '0;
    else if (inc_i && (cnt_q != TOP)) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R4
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == TOP && !clr_i) |=> cnt_q == TOP);

  // R5
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> cnt_q <= ERRW'(1));

endmodule

// File: rtl/t0_char_rx.sv
module t0_char_rx #(
  parameter int BIT_TICKS = 16,
  parameter int MAXW      = 3,
  parameter int ERRW      = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bit_tick,
  input  logic            io_line,
  output logic            io_pull_low,
  input  logic            cfg_nack_inhibit,
  input  logic            cfg_nack_limit_en,
  input  logic [MAXW-1:0] cfg_nack_max,
  output logic [7:0]      rx_byte,
  output logic            rx_ready,
  input  logic            rx_taken,
  output logic [ERRW-1:0] err_count,
  input  logic            err_count_rd,
  output logic            inack_flag,
  input  logic            inack_clr,
  output logic            iter_flag,
  input  logic            iter_clr
);

  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  logic       frm_done;
  logic [7:0] frm_byte;
  logic       frm_par_ok;
  logic       pol_nack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  t0rx_frame #(.BIT_TICKS(BIT_TICKS)) u_frame (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .tick_i   (bit_tick),
    .line_i   (io_line),
    .nack_i   (pol_nack),
    .done_o   (frm_done),
    .byte_o   (frm_byte),
    .par_ok_o (frm_par_ok),
    .drive_o  (io_pull_low)
  );

  t0rx_policy #(.MAXW(MAXW)) u_policy (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .done_i      (frm_done),
    .par_ok_i    (frm_par_ok),
    .byte_i      (frm_byte),
    .inhibit_i   (cfg_nack_inhibit),
    .limit_en_i  (cfg_nack_limit_en),
    .max_i       (cfg_nack_max),
    .taken_i     (rx_taken),
    .clr_inack_i (inack_clr),
    .clr_iter_i  (iter_clr),
    .nack_o      (pol_nack),
    .data_o      (rx_byte),
    .ready_o     (rx_ready),
    .inack_o     (inack_flag),
    .iter_o      (iter_flag)
  );

  t0rx_errcnt #(.ERRW(ERRW)) u_errcnt (
    .clk   (clk),
    .rst_n (rst_core_n),
    .inc_i (frm_done && !frm_par_ok),
    .clr_i (err_count_rd),
    .cnt_o (err_count)
  );

  // R11
  taken_clears_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (rx_taken && !frm_done) |=> !rx_ready);

endmodule

// File: tb/t0_char_rx_test.sv
module t0_char_rx_test;

  localparam int BT = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick;
  logic       tx;
  logic       io_line;
  logic       io_pull_low;
  logic       cfg_inh, cfg_lim;
  logic [2:0] cfg_max;
  logic [7:0] rx_byte;
  logic       rx_ready, rx_taken;
  logic [7:0] err_count;
  logic       err_rd;
  logic       inack_flag, inack_clr, iter_flag, iter_clr;

  int checks = 0;
  int fails  = 0;
  int drv_cycles;
  int exp_err;
  bit finished = 0;

  always #5 clk = ~clk;

  assign io_line = tx & ~io_pull_low;

  t0_char_rx #(.BIT_TICKS(BT)) uut (
    .clk(clk), .rst_n(rst_n), .bit_tick(tick), .io_line(io_line),
    .io_pull_low(io_pull_low), .cfg_nack_inhibit(cfg_inh),
    .cfg_nack_limit_en(cfg_lim), .cfg_nack_max(cfg_max),
    .rx_byte(rx_byte), .rx_ready(rx_ready), .rx_taken(rx_taken),
    .err_count(err_count), .err_count_rd(err_rd),
    .inack_flag(inack_flag), .inack_clr(inack_clr),
    .iter_flag(iter_flag), .iter_clr(iter_clr)
  );

  always @(negedge clk) begin
    if (!rst_n) tick <= 1'b0;
    else        tick <= ~tick;
    if (io_pull_low) drv_cycles <= drv_cycles + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      while (!tick) @(posedge clk);
    end
  endtask

  task automatic send(input logic [7:0] d, input bit bad);
    logic par;
    par = ^d ^ bad;
    @(negedge clk); drv_cycles = 0; tx = 1'b0;
    wait_ticks(BT);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); tx = d[i];
      wait_ticks(BT);
    end
    @(negedge clk); tx = par;
    wait_ticks(BT);
    @(negedge clk); tx = 1'b1;
    wait_ticks(4 * BT);
    @(negedge clk);
    if (bad && exp_err < 255) exp_err++;
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
    @(negedge clk);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    report();
  end

  initial begin
    rst_n = 1'b0; tx = 1'b1; cfg_inh = 0; cfg_lim = 0; cfg_max = 0;
    rx_taken = 0; err_rd = 0; inack_clr = 0; iter_clr = 0;
    drv_cycles = 0; exp_err = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    check("R1 reset ready", rx_ready, 0);
    check("R4 reset count", err_count, 0);
    check("R7 reset inack", inack_flag, 0);
    check("R9 reset iter", iter_flag, 0);
    check("R3 reset drive", io_pull_low, 0);

    // R1 R2 R3 R11: every byte with good parity
    for (int v = 0; v < 256; v++) begin
      send(8'(v), 1'b0);
      check("R1 data", rx_byte, v);
      check("R2 good ready", rx_ready, 1);
      check("R3 no nack on good", drv_cycles, 0);
      pulse(rx_taken);
      check("R11 taken clears", rx_ready, 0);
    end
    check("R2 no errors", err_count, 0);

    // R3 R4: bad parity, plain NACK
    for (int v = 0; v < 16; v++) begin
      send(8'(v * 17 + 3), 1'b1);
      check("R3 nack length", drv_cycles, 2 * BT);
      check("R3 not stored", rx_byte, 255);
      check("R3 no ready", rx_ready, 0);
      check("R4 count", err_count, exp_err);
    end

    // R5
    pulse(err_rd); exp_err = 0;
    check("R5 read clears", err_count, 0);

    // R6 R7
    cfg_inh = 1;
    send(8'h5A, 1'b1);
    check("R6 no drive", drv_cycles, 0);
    check("R6 stored", rx_byte, 8'h5A);
    check("R6 no ready", rx_ready, 0);
    check("R6 flag", inack_flag, 1);
    check("R4 inhibited counted", err_count, 1);
    cfg_inh = 0;
    send(8'hC3, 1'b0);
    check("R7 sticky", inack_flag, 1);
    pulse(rx_taken);
    pulse(inack_clr);
    check("R7 cleared", inack_flag, 0);

    // R8 R9 R10: cap of 2
    cfg_lim = 1; cfg_max = 3'd2;
    send(8'h11, 1'b1); check("R8 nack 1", drv_cycles, 2 * BT);
    send(8'h11, 1'b1); check("R8 nack 2", drv_cycles, 2 * BT);
    check("R8 no iter yet", iter_flag, 0);
    send(8'h11, 1'b1);
    check("R8 forced no drive", drv_cycles, 0);
    check("R8 forced stored", rx_byte, 8'h11);
    check("R8 forced ready", rx_ready, 1);
    check("R8 iter set", iter_flag, 1);
    pulse(rx_taken);
    send(8'h22, 1'b1); check("R8 nack after accept", drv_cycles, 2 * BT);
    send(8'h33, 1'b0); check("R10 good", rx_byte, 8'h33);
    pulse(rx_taken);
    check("R9 sticky", iter_flag, 1);
    pulse(iter_clr);
    check("R9 cleared", iter_flag, 0);
    send(8'h44, 1'b1); check("R10 nack 1 after good", drv_cycles, 2 * BT);
    send(8'h44, 1'b1); check("R10 nack 2 after good", drv_cycles, 2 * BT);
    send(8'h44, 1'b1); check("R10 third accepted", drv_cycles, 0);
    check("R10 iter again", iter_flag, 1);
    pulse(rx_taken);
    pulse(iter_clr);
    cfg_max = 3'd0;
    send(8'h66, 1'b1);
    check("R8 max zero accepts", drv_cycles, 0);
    check("R8 max zero ready", rx_ready, 1);
    pulse(rx_taken);
    cfg_lim = 0;

    // R12: false start
    @(negedge clk); drv_cycles = 0; tx = 1'b0;
    wait_ticks(1);
    @(negedge clk); tx = 1'b1;
    wait_ticks(4 * BT);
    @(negedge clk);
    check("R12 no ready", rx_ready, 0);
    check("R12 no error", err_count, exp_err);
    check("R12 no drive", drv_cycles, 0);
    send(8'h81, 1'b0);
    check("R12 next frame ok", rx_byte, 8'h81);
    pulse(rx_taken);

    // R4: saturation
    cfg_inh = 1;
    for (int i = 0; i < 260; i++) send(8'(i), 1'b1);
    check("R4 saturated", err_count, 255);
    check("R4 model", exp_err, 255);
    pulse(err_rd);
    check("R5 clear from top", err_count, 0);

    report();
  end

endmodule